// File: doc/BRIEF.md
# Automatic RTS/CTS Handshake Controller

This block provides one serial channel's automatic hardware handshaking. On the receive side it compares the receive FIFO fill count with a pair of thresholds. The pair is chosen by a two-bit trigger code. The block drives the active-low request-to-send output with hysteresis. RTS goes off one trigger step above the programmed level and comes back on one step below it. The FIFO keeps accepting characters while RTS is off until it is full, but that is the FIFO's own business. When automatic RTS is switched off, the pin simply follows a manual request bit from the modem control register.

On the transmit side the block synchronises the asynchronous active-low clear-to-send input through two flops. It then gates the transmit shifter. A stop request never cuts a character short. If a character is being shifted when the stop arrives, the shifter keeps running until it reports that the stop bit has gone out, and only then is it held. A change of the synchronised CTS level can raise a sticky status flag, which a clear pulse removes.

The receive side runs a two-state machine: RTS_ON (pin low) and RTS_OFF (pin high). It moves RTS_ON to RTS_OFF when the count reaches the off level and auto-RTS is enabled. It moves RTS_OFF to RTS_ON when the count falls to the on level or auto-RTS is disabled. The transmit side runs three states: TX_RUN (enabled), TX_DRAIN (stop pending, current character finishing, still enabled) and TX_HOLD (disabled). Its transitions are as follows. TX_RUN goes to TX_DRAIN on a stop request while a character is active. TX_RUN goes to TX_HOLD on a stop request while idle, or when the character completes in that cycle. TX_DRAIN goes to TX_HOLD on the character-complete pulse. Both TX_DRAIN and TX_HOLD return to TX_RUN when the stop request goes away.

Top module: `auto_handshake_ctrl`

## Requirements
- R1: While reset is held, rts_n is 1, tx_en is 1 and cts_irq is 0.
- R2: With auto-RTS enabled and trig_sel = 0 (level 8), rts_n rises one clock after rx_count reaches 16 or more, and falls one clock after rx_count reaches 0.
- R3: With trig_sel = 1 (level 16), rts_n goes high at a count of 56 or more and low at 8 or less.
- R4: With trig_sel = 2 (level 56), rts_n goes high at a count of 60 or more and low at 16 or less.
- R5: With trig_sel = 3 (level 60), rts_n goes high at a count of 60 or more and low at 56 or less.
- R6: A count strictly between the on level and the off level leaves rts_n unchanged in either direction.
- R7: With auto-RTS disabled, rts_n equals the inverse of rts_manual one clock later, whatever rx_count is.
- R8: With auto-CTS enabled and no character active, tx_en falls on the third clock edge after cts_n_pin goes high (two synchroniser flops plus the state register), and not before.
- R9: If a character is active (tx_active = 1) when the stop request arrives, tx_en stays 1 until char_done pulses, and falls on the edge following that pulse.
- R10: When cts_n_pin returns low, tx_en rises on the third clock edge after the change.
- R11: With auto-CTS disabled, cts_n_pin has no effect on tx_en, which stays 1.
- R12: When cts_irq_en is 1, a change of the synchronised CTS level in either direction sets cts_irq on the third edge after the pin change. cts_irq_clr clears it on the next edge. When cts_irq_en is 0, CTS changes leave cts_irq at 0.
- R13: Disabling auto-CTS while transmission is held sets tx_en to 1 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rts_auto_en | input | 1 | Automatic RTS enable |
| cts_auto_en | input | 1 | Automatic CTS enable |
| trig_sel | input | 2 | Receive trigger code: 0=8, 1=16, 2=56, 3=60 characters |
| rx_count | input | CNT_W (7) | Receive FIFO fill count |
| rts_manual | input | 1 | Manual RTS request, 1 drives rts_n low when auto-RTS is off |
| cts_n_pin | input | 1 | Asynchronous active-low clear-to-send pin |
| tx_active | input | 1 | Transmit shifter is mid-character |
| char_done | input | 1 | One-cycle pulse: stop bit of current character sent |
| cts_irq_en | input | 1 | Enable for the CTS change status flag |
| cts_irq_clr | input | 1 | Clear pulse for the CTS change status flag |
| rts_n | output | 1 | Active-low request-to-send |
| tx_en | output | 1 | Transmit shifter run enable |
| cts_irq | output | 1 | Sticky CTS change status flag |

## Verification
The bench approaches each threshold pair from both sides. A design that swapped the off and on levels, used a strict instead of an inclusive compare, or dropped the hysteresis would flip rts_n one count early or late, or would chatter in the band between the levels. The CTS path is sampled on every edge of its latency, so a missing or extra synchroniser flop shows up as tx_en or cts_irq moving one clock off. The mid-character case holds the stop request for several cycles before char_done arrives, which catches a design that truncates the character by dropping tx_en straight away.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [0:0] {
        RTS_ON  = 1'b0,
        RTS_OFF = 1'b1
    } rts_state_e;

    typedef enum logic [1:0] {
        TX_RUN   = 2'd0,
        TX_DRAIN = 2'd1,
        TX_HOLD  = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        TRIG_L0 = 2'd0,
        TRIG_L1 = 2'd1,
        TRIG_L2 = 2'd2,
        TRIG_L3 = 2'd3
    } trig_code_e;

endpackage

// File: rtl/hs_cts_watch.sv
module hs_cts_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_pin,
    input  logic irq_en,
    input  logic irq_clr,
    output logic cts_high,
    output logic irq
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   change;

    // Synchroniser chain; reset assumes clear-to-send.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n_pin};
        end
    end

    assign cts_high = sync_q[SYNC_STAGES-1];
    assign change   = cts_high ^ last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= cts_high;
        end
    end

    // Sticky flag: a new change wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (change && irq_en) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/hs_rts_fsm.sv
module hs_rts_fsm
    import hs_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int LVL0  = 8,
    parameter int LVL1  = 16,
    parameter int LVL2  = 56,
    parameter int LVL3  = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             manual_req,
    output logic             rts_n
);

    localparam logic [CNT_W-1:0] L0 = CNT_W'(LVL0);
    localparam logic [CNT_W-1:0] L1 = CNT_W'(LVL1);
    localparam logic [CNT_W-1:0] L2 = CNT_W'(LVL2);
    localparam logic [CNT_W-1:0] L3 = CNT_W'(LVL3);

    rts_state_e       state_q, state_d;
    logic [CNT_W-1:0] off_lvl;
    logic [CNT_W-1:0] on_lvl;
    trig_code_e       code;

    assign code = trig_code_e'(trig_sel);

    // Off level one step above the trigger, on level one step below.
    always_comb begin
        unique case (code)
            TRIG_L0: begin off_lvl = L1; on_lvl = '0; end
            TRIG_L1: begin off_lvl = L2; on_lvl = L0; end
            TRIG_L2: begin off_lvl = L3; on_lvl = L1; end
            TRIG_L3: begin off_lvl = L3; on_lvl = L2; end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_ON: begin
                if (auto_en && (rx_count >= off_lvl)) state_d = RTS_OFF;
            end
            RTS_OFF: begin
                if (!auto_en || (rx_count <= on_lvl)) state_d = RTS_ON;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RTS_ON;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register, driven from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_n <= 1'b1;
        end else if (auto_en) begin
            rts_n <= (state_d == RTS_OFF);
        end else begin
            rts_n <= !manual_req;
        end
    end

endmodule

// File: rtl/hs_tx_gate.sv
module hs_tx_gate
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic tx_active,
    input  logic char_done,
    output logic tx_en
);

    tx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_RUN: begin
                if (stop_req) begin
                    if (tx_active && !char_done) state_d = TX_DRAIN;
                    else                         state_d = TX_HOLD;
                end
            end
            TX_DRAIN: begin
                if (!stop_req)      state_d = TX_RUN;
                else if (char_done) state_d = TX_HOLD;
            end
            TX_HOLD: begin
                if (!stop_req) state_d = TX_RUN;
            end
            default: state_d = TX_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en <= 1'b1;
        end else begin
            tx_en <= (state_d != TX_HOLD);
        end
    end

endmodule

// File: rtl/auto_handshake_ctrl.sv
module auto_handshake_ctrl #(
    parameter int FIFO_DEPTH  = 64,
    parameter int LVL0        = 8,
    parameter int LVL1        = 16,
    parameter int LVL2        = 56,
    parameter int LVL3        = 60,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rts_auto_en,
    input  logic             cts_auto_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rts_manual,
    input  logic             cts_n_pin,
    input  logic             tx_active,
    input  logic             char_done,
    input  logic             cts_irq_en,
    input  logic             cts_irq_clr,
    output logic             rts_n,
    output logic             tx_en,
    output logic             cts_irq
);

    logic cts_high;
    logic stop_req;

    hs_cts_watch #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cts (
        .clk       (clk),
        .rst_n     (rst_n),
        .cts_n_pin (cts_n_pin),
        .irq_en    (cts_irq_en),
        .irq_clr   (cts_irq_clr),
        .cts_high  (cts_high),
        .irq       (cts_irq)
    );

    assign stop_req = cts_auto_en && cts_high;

    hs_tx_gate u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_req  (stop_req),
        .tx_active (tx_active),
        .char_done (char_done),
        .tx_en     (tx_en)
    );

    hs_rts_fsm #(
        .CNT_W (CNT_W),
        .LVL0  (LVL0),
        .LVL1  (LVL1),
        .LVL2  (LVL2),
        .LVL3  (LVL3)
    ) u_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (rts_auto_en),
        .trig_sel   (trig_sel),
        .rx_count   (rx_count),
        .manual_req (rts_manual),
        .rts_n      (rts_n)
    );

endmodule

// File: rtl/auto_handshake_ctrl_chk.sv
module auto_handshake_ctrl_chk #(
    parameter int CNT_W = 7,
    parameter int LVL1  = 16,
    parameter int LVL3  = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rts_auto_en,
    input logic             cts_auto_en,
    input logic [CNT_W-1:0] rx_count,
    input logic             rts_manual,
    input logic             tx_active,
    input logic             char_done,
    input logic             cts_irq_en,
    input logic             rts_n,
    input logic             tx_en,
    input logic             cts_irq
);

    // R2: an empty FIFO under auto-RTS always leaves RTS asserted
    a_r2_empty_on: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && rx_count == '0) |=> !rts_n);

    // R5: a count at the top level is at or above every off level
    a_r5_full_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_auto_en && rx_count >= CNT_W'(LVL3)) |=> rts_n);

    // R6: under auto-RTS, RTS only goes off at or above the lowest off level
    a_r6_off_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rts_n) && $past(rts_auto_en)) |-> ($past(rx_count) >= CNT_W'(LVL1)));

    // R7: manual mode follows the request bit
    a_r7_manual: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_auto_en |=> (rts_n == !$past(rts_manual)));

    // R9: a running character is never cut before its stop bit
    a_r9_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_active && !char_done) |=> tx_en);

    // R11: without auto-CTS the transmitter is never held
    a_r11_cts_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cts_auto_en |=> tx_en);

    // R12: the flag is only raised while enabled
    a_r12_flag_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cts_irq) |-> $past(cts_irq_en));

endmodule

bind auto_handshake_ctrl auto_handshake_ctrl_chk #(
    .CNT_W (CNT_W),
    .LVL1  (LVL1),
    .LVL3  (LVL3)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rts_auto_en (rts_auto_en),
    .cts_auto_en (cts_auto_en),
    .rx_count    (rx_count),
    .rts_manual  (rts_manual),
    .tx_active   (tx_active),
    .char_done   (char_done),
    .cts_irq_en  (cts_irq_en),
    .rts_n       (rts_n),
    .tx_en       (tx_en),
    .cts_irq     (cts_irq)
);

// File: tb/auto_handshake_ctrl_tb.sv
module auto_handshake_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rts_auto_en, cts_auto_en;
    logic [1:0]    trig_sel;
    logic [CW-1:0] rx_count;
    logic          rts_manual, cts_n_pin, tx_active, char_done;
    logic          cts_irq_en, cts_irq_clr;
    logic          rts_n, tx_en, cts_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    auto_handshake_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rts_auto_en (rts_auto_en),
        .cts_auto_en (cts_auto_en),
        .trig_sel    (trig_sel),
        .rx_count    (rx_count),
        .rts_manual  (rts_manual),
        .cts_n_pin   (cts_n_pin),
        .tx_active   (tx_active),
        .char_done   (char_done),
        .cts_irq_en  (cts_irq_en),
        .cts_irq_clr (cts_irq_clr),
        .rts_n       (rts_n),
        .tx_en       (tx_en),
        .cts_irq     (cts_irq)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Inputs change and outputs are sampled at the falling edge.
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rts_auto_en = 1'b0; cts_auto_en = 1'b0; trig_sel = 2'd0;
        rx_count = '0; rts_manual = 1'b0; cts_n_pin = 1'b0; tx_active = 1'b0;
        char_done = 1'b0; cts_irq_en = 1'b0; cts_irq_clr = 1'b0;
        step(3);
        chk("R1", "rts_n in reset", rts_n, 1'b1);
        chk("R1", "tx_en in reset", tx_en, 1'b1);
        chk("R1", "cts_irq in reset", cts_irq, 1'b0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_level(input string req, input logic [1:0] sel, input int off_c, input int on_c);
        rts_auto_en = 1'b1; trig_sel = sel;
        rx_count = '0; step(1);
        chk(req, "on when empty", rts_n, 1'b0);
        rx_count = CW'(off_c - 1); step(1);
        chk("R6", "below off level stays on", rts_n, 1'b0);
        rx_count = CW'(off_c); step(1);
        chk(req, "off at off level", rts_n, 1'b1);
        rx_count = CW'(on_c + 1); step(1);
        chk("R6", "above on level stays off", rts_n, 1'b1);
        rx_count = CW'(on_c); step(1);
        chk(req, "on at on level", rts_n, 1'b0);
        rx_count = '0; step(1);
    endtask

    task automatic t_manual();
        rts_auto_en = 1'b0; rx_count = CW'(64); rts_manual = 1'b1; step(1);
        chk("R7", "manual request drives low", rts_n, 1'b0);
        rts_manual = 1'b0; rx_count = '0; step(1);
        chk("R7", "manual release drives high", rts_n, 1'b1);
    endtask

    task automatic t_cts_idle();
        cts_auto_en = 1'b1; tx_active = 1'b0;
        cts_n_pin = 1'b1; step(2);
        chk("R8", "tx_en before sync latency", tx_en, 1'b1);
        step(1);
        chk("R8", "tx_en held after three edges", tx_en, 1'b0);
        cts_n_pin = 1'b0; step(2);
        chk("R10", "still held during sync", tx_en, 1'b0);
        step(1);
        chk("R10", "resumed after three edges", tx_en, 1'b1);
    endtask

    task automatic t_cts_midchar();
        cts_auto_en = 1'b1; tx_active = 1'b1;
        cts_n_pin = 1'b1; step(3);
        chk("R9", "running character keeps enable", tx_en, 1'b1);
        step(5);
        chk("R9", "enable kept until stop bit", tx_en, 1'b1);
        char_done = 1'b1; step(1);
        char_done = 1'b0; tx_active = 1'b0;
        chk("R9", "held after char_done", tx_en, 1'b0);
        cts_n_pin = 1'b0; step(3);
        chk("R10", "resume after mid-char stop", tx_en, 1'b1);
    endtask

    task automatic t_irq();
        cts_irq_clr = 1'b1; step(1); cts_irq_clr = 1'b0;
        cts_irq_en = 1'b1; cts_n_pin = 1'b1; step(2);
        chk("R12", "flag before latency", cts_irq, 1'b0);
        step(1);
        chk("R12", "flag on rising change", cts_irq, 1'b1);
        cts_irq_clr = 1'b1; step(1); cts_irq_clr = 1'b0;
        chk("R12", "flag cleared", cts_irq, 1'b0);
        cts_n_pin = 1'b0; step(3);
        chk("R12", "flag on falling change", cts_irq, 1'b1);
        cts_irq_clr = 1'b1; step(1); cts_irq_clr = 1'b0;
        cts_irq_en = 1'b0; cts_n_pin = 1'b1; step(4);
        chk("R12", "no flag when disabled", cts_irq, 1'b0);
        cts_n_pin = 1'b0; step(4);
    endtask

    task automatic t_cts_disabled();
        cts_auto_en = 1'b0; cts_n_pin = 1'b1; step(5);
        chk("R11", "pin ignored when auto-CTS off", tx_en, 1'b1);
    endtask

    task automatic t_disable_release();
        cts_auto_en = 1'b1; step(1);
        chk("R13", "held with pin high", tx_en, 1'b0);
        cts_auto_en = 1'b0; step(1);
        chk("R13", "released on disable", tx_en, 1'b1);
        cts_n_pin = 1'b0; step(4);
    endtask

    initial begin
        t_reset();
        t_level("R2", 2'd0, 16, 0);
        t_level("R3", 2'd1, 56, 8);
        t_level("R4", 2'd2, 60, 16);
        t_level("R5", 2'd3, 60, 56);
        t_manual();
        t_cts_idle();
        t_cts_midchar();
        t_irq();
        t_cts_disabled();
        t_disable_release();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule